// File: doc/BRIEF.md
# Register-List Replay Engine

This engine lets software prepare batches of register updates in memory and have them applied by hardware, with no processor writes in the timing-critical window. Each batch is a list of 8-byte entries. Each entry holds a 32-bit value word followed by a 32-bit register-offset word. For every entry the engine reads both words over a word-read memory port and then issues one write on an address/data write port.

There are three lists, grouped in two buffers:
- A single buffer with an urgent part and a relaxed part. Both parts share one base address, and the relaxed entries are stored directly after the urgent ones.
- A double buffer with its own base address and count. It is replayed only on the next frame-start pulse that follows the single-buffer work.

Software programs the bases and counts, then sets the run bit. The engine walks the lists in arbitration order and sets one completion flag per list it replayed. When all the work is done it clears the run bit by itself. A failed memory read or a failed register write stops the run and is reported as an error. Two sequencing hazards are reported without stopping the run. All flags are write-one-to-clear, and each flag has its own interrupt enable.

Top module: `reglist_loader`

## Requirements
- R1: After reset every register reads 0, `irq` is 0, and neither `rd_req` nor `wr_en` is asserted.
- R2: Register map, with byte offsets on `cfg_addr`:
  - 0x00 control/status: bit 0 run, bit 1 order select, bits 8:2 interrupt enables, bits 22:16 flags. Flags and enables use the same order, lowest bit first: read error, double-buffer done, urgent done, relaxed done, frame-while-single-pending, display-active-while-single-pending, write error.
  - 0x10 double-buffer base; 0x14 double-buffer count in bits 15:0.
  - 0x18 single-buffer base; 0x1C urgent count in bits 15:0 and relaxed count in bits 31:16.
  - 0x20 failing write offset.
- R3: Entry i of a list sits at base + 8·i. The value word is at +0 and the offset word at +4. The engine writes `wr_data`=value and `wr_addr`=offset. The relaxed list starts at single-buffer base + 8 × urgent count.
- R4: With order select 0 the urgent list is replayed before the relaxed list; with order select 1 the relaxed list goes first. Double-buffer entries are written only after a `frame_start` pulse seen once both single-buffer lists are finished.
- R5: A list whose count is 0 is skipped. If the double-buffer count is 0, no frame wait takes place.
- R6: Each replayed list with a non-zero count sets its done flag. After the last list the run bit returns to 0 without software action.
- R7: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R8: Writing 1 to the run bit while it is 1 does not restart the run. Writes to the base, count and order-select fields are ignored while the run bit is 1.
- R9: A read response with `rd_err` high sets the read-error flag (bit 16), ends the run, and clears the run bit. No further writes are issued.
- R10: A write with `wr_err` high sets the write-error flag (bit 22) and latches the offset into 0x20. It also ends the run and clears the run bit.
- R11: A `frame_start` pulse during single-buffer replay while the double-buffer count is non-zero sets bit 20. `display_active` high during single-buffer replay sets bit 21. Neither stops the run.
- R12: `irq` is a register holding the OR of (flags AND enables) from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register byte offset |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data at `cfg_addr` |
| frame_start | input | 1 | Frame-start pulse releasing the double buffer |
| display_active | input | 1 | Display active-region indicator |
| rd_req | output | 1 | One-cycle memory read request |
| rd_addr | output | AW | Memory byte address |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | DW | Read response word |
| rd_err | input | 1 | Read response error |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | DW | Target register offset |
| wr_data | output | DW | Value to write |
| wr_err | input | 1 | Write failed, same cycle as `wr_en` |
| irq | output | 1 | Interrupt |

## Verification
The bench uses the default widths: 32-bit addresses and data, and 16-bit counts. The 32-bit offset words let every replayed entry carry a distinct target address, so misordered or repeated writes are visible at the write port. List lengths are kept to a few entries. This keeps runs short while still covering both order settings, zero counts, the frame wait, injected read and write faults at a chosen entry, and locking of the register file during a run.

// File: rtl/reglist_pkg.sv
package reglist_pkg;
  localparam int REG_AW = 6;
  localparam int NFLAG  = 7;
  // flag positions (status bits 16+k, enable bits 2+k)
  localparam int F_RD   = 0;
  localparam int F_DB   = 1;
  localparam int F_HP   = 2;
  localparam int F_LP   = 3;
  localparam int F_FRM  = 4;
  localparam int F_DISP = 5;
  localparam int F_BUS  = 6;
  localparam logic [REG_AW-1:0] A_CTL = 6'h00;
  localparam logic [REG_AW-1:0] A_DBB = 6'h10;
  localparam logic [REG_AW-1:0] A_DBC = 6'h14;
  localparam logic [REG_AW-1:0] A_SBB = 6'h18;
  localparam logic [REG_AW-1:0] A_SBC = 6'h1C;
  localparam logic [REG_AW-1:0] A_ERR = 6'h20;
  typedef enum logic [1:0] {L_HP, L_LP, L_DB} list_e;
  typedef enum logic [2:0] {S_IDLE, S_PICK, S_FRAME, S_RV_REQ, S_RV_WAIT,
                            S_RO_REQ, S_RO_WAIT, S_WR} seq_st_e;
endpackage

// File: rtl/reglist_regs.sv
module reglist_regs
  import reglist_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NFLAG-1:0]  evt_i,
  input  logic              clr_en_i,
  input  logic [DW-1:0]     err_addr_i,
  output logic              go_o,
  output logic              arb_o,
  output logic [AW-1:0]     db_base_o,
  output logic [CW-1:0]     db_cnt_o,
  output logic [AW-1:0]     sb_base_o,
  output logic [CW-1:0]     hp_cnt_o,
  output logic [CW-1:0]     lp_cnt_o,
  output logic              irq_o
);
  logic             en_q, en_d, arb_q, arb_d, irq_q, irq_d;
  logic [NFLAG-1:0] ien_q, ien_d, sts_q, sts_d;
  logic [AW-1:0]    dbb_q, dbb_d, sbb_q, sbb_d;
  logic [CW-1:0]    dbc_q, dbc_d, hpc_q, hpc_d, lpc_q, lpc_d;
  logic [DW-1:0]    err_q, err_d;
  logic             wr_ctl, cfg_ok;
  logic             unused_bits;

  assign unused_bits = ^wdata_i;

  always_comb begin
    wr_ctl = we_i && (addr_i == A_CTL);
    cfg_ok = we_i && !en_q;
    go_o   = wr_ctl && wdata_i[0] && !en_q;
    en_d   = en_q;
    if (go_o)          en_d = 1'b1;
    else if (clr_en_i) en_d = 1'b0;
    arb_d  = (wr_ctl && !en_q) ? wdata_i[1] : arb_q;
    ien_d  = wr_ctl ? wdata_i[2+NFLAG-1:2] : ien_q;
    sts_d  = (sts_q & ~(wr_ctl ? wdata_i[16+NFLAG-1:16] : '0)) | evt_i;
    dbb_d  = (cfg_ok && addr_i == A_DBB) ? wdata_i[AW-1:0] : dbb_q;
    sbb_d  = (cfg_ok && addr_i == A_SBB) ? wdata_i[AW-1:0] : sbb_q;
    dbc_d  = (cfg_ok && addr_i == A_DBC) ? wdata_i[CW-1:0] : dbc_q;
    hpc_d  = (cfg_ok && addr_i == A_SBC) ? wdata_i[CW-1:0] : hpc_q;
    lpc_d  = (cfg_ok && addr_i == A_SBC) ? wdata_i[16+CW-1:16] : lpc_q;
    err_d  = evt_i[F_BUS] ? err_addr_i : err_q;
    irq_d  = |(sts_q & ien_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; arb_q <= 1'b0; irq_q <= 1'b0;
      ien_q <= '0; sts_q <= '0;
      dbb_q <= '0; sbb_q <= '0; dbc_q <= '0; hpc_q <= '0; lpc_q <= '0;
      err_q <= '0;
    end else begin
      en_q <= en_d; arb_q <= arb_d; irq_q <= irq_d;
      ien_q <= ien_d; sts_q <= sts_d;
      dbb_q <= dbb_d; sbb_q <= sbb_d; dbc_q <= dbc_d; hpc_q <= hpc_d; lpc_q <= lpc_d;
      err_q <= err_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTL: begin
        rdata_o[0] = en_q;
        rdata_o[1] = arb_q;
        rdata_o[2+NFLAG-1:2]   = ien_q;
        rdata_o[16+NFLAG-1:16] = sts_q;
      end
      A_DBB: rdata_o[AW-1:0] = dbb_q;
      A_DBC: rdata_o[CW-1:0] = dbc_q;
      A_SBB: rdata_o[AW-1:0] = sbb_q;
      A_SBC: begin
        rdata_o[CW-1:0]     = hpc_q;
        rdata_o[16+CW-1:16] = lpc_q;
      end
      A_ERR: rdata_o = err_q;
      default: rdata_o = '0;
    endcase
  end

  assign arb_o     = arb_q;
  assign db_base_o = dbb_q;
  assign sb_base_o = sbb_q;
  assign db_cnt_o  = dbc_q;
  assign hp_cnt_o  = hpc_q;
  assign lp_cnt_o  = lpc_q;
  assign irq_o     = irq_q;

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_q) |-> ($stable(dbb_q) && $stable(sbb_q) && $stable(dbc_q) && $stable(hpc_q) && $stable(lpc_q))); // R8
  AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en_i |=> !en_q); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && wdata_i[2+NFLAG-1:2] == '0) |-> ##2 !irq_o); // R12
  for (genvar k = 0; k < NFLAG; k++) begin : g_flag_chk
    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_q[k]) |-> $past(evt_i[k])); // R7
  end
endmodule

// File: rtl/reglist_seq.sv
module reglist_seq
  import reglist_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             arb_i,
  input  logic [AW-1:0]    db_base_i,
  input  logic [CW-1:0]    db_cnt_i,
  input  logic [AW-1:0]    sb_base_i,
  input  logic [CW-1:0]    hp_cnt_i,
  input  logic [CW-1:0]    lp_cnt_i,
  input  logic             frame_i,
  input  logic             disp_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [DW-1:0]    mem_rdata_i,
  input  logic             mem_rerr_i,
  output logic             wr_en_o,
  output logic [DW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_data_o,
  input  logic             wr_err_i,
  output logic [NFLAG-1:0] evt_o,
  output logic             clr_en_o,
  output logic [DW-1:0]    err_addr_o
);
  localparam int ENTRY_B = 8;
  localparam int WORD_B  = 4;

  seq_st_e       st_q, st_d;
  list_e         cur_q, cur_d, pick_id;
  logic [1:0]    step_q, step_d;
  logic [AW-1:0] ptr_q, ptr_d, pick_base;
  logic [CW-1:0] left_q, left_d, pick_cnt;
  logic [DW-1:0] val_q, val_d, ofs_q, ofs_d;
  logic          sb_busy;

  always_comb begin
    unique case (step_q)
      2'd0:    pick_id = arb_i ? L_LP : L_HP;
      2'd1:    pick_id = arb_i ? L_HP : L_LP;
      default: pick_id = L_DB;
    endcase
    unique case (pick_id)
      L_HP: begin pick_cnt = hp_cnt_i; pick_base = sb_base_i; end
      L_LP: begin pick_cnt = lp_cnt_i; pick_base = sb_base_i + (AW'(hp_cnt_i) << 3); end
      default: begin pick_cnt = db_cnt_i; pick_base = db_base_i; end
    endcase
  end

  always_comb begin
    st_d = st_q; cur_d = cur_q; step_d = step_q; ptr_d = ptr_q;
    left_d = left_q; val_d = val_q; ofs_d = ofs_q;
    evt_o = '0; clr_en_o = 1'b0; mem_req_o = 1'b0; wr_en_o = 1'b0;
    sb_busy = (cur_q != L_DB) && (st_q inside {S_RV_REQ, S_RV_WAIT, S_RO_REQ, S_RO_WAIT, S_WR});
    evt_o[F_FRM]  = sb_busy && frame_i && (db_cnt_i != '0);
    evt_o[F_DISP] = sb_busy && disp_i;
    unique case (st_q)
      S_IDLE: if (go_i) begin step_d = 2'd0; st_d = S_PICK; end
      S_PICK: begin
        if (step_q == 2'd3) begin
          clr_en_o = 1'b1;
          st_d     = S_IDLE;
        end else if (pick_cnt == '0) begin
          step_d = step_q + 2'd1;
        end else begin
          cur_d  = pick_id;
          ptr_d  = pick_base;
          left_d = pick_cnt;
          st_d   = (pick_id == L_DB) ? S_FRAME : S_RV_REQ;
        end
      end
      S_FRAME:  if (frame_i) st_d = S_RV_REQ;
      S_RV_REQ: begin mem_req_o = 1'b1; st_d = S_RV_WAIT; end
      S_RO_REQ: begin mem_req_o = 1'b1; st_d = S_RO_WAIT; end
      S_RV_WAIT, S_RO_WAIT: if (mem_rvalid_i) begin
        if (mem_rerr_i) begin
          evt_o[F_RD] = 1'b1; clr_en_o = 1'b1; st_d = S_IDLE;
        end else if (st_q == S_RV_WAIT) begin
          val_d = mem_rdata_i; st_d = S_RO_REQ;
        end else begin
          ofs_d = mem_rdata_i; st_d = S_WR;
        end
      end
      S_WR: begin
        wr_en_o = 1'b1;
        if (wr_err_i) begin
          evt_o[F_BUS] = 1'b1; clr_en_o = 1'b1; st_d = S_IDLE;
        end else begin
          left_d = left_q - 1'b1;
          ptr_d  = ptr_q + AW'(ENTRY_B);
          if (left_q == CW'(1)) begin
            unique case (cur_q)
              L_HP:    evt_o[F_HP] = 1'b1;
              L_LP:    evt_o[F_LP] = 1'b1;
              default: evt_o[F_DB] = 1'b1;
            endcase
            step_d = step_q + 2'd1;
            st_d   = S_PICK;
          end else begin
            st_d = S_RV_REQ;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cur_q <= L_HP; step_q <= '0; ptr_q <= '0;
      left_q <= '0; val_q <= '0; ofs_q <= '0;
    end else begin
      st_q <= st_d; cur_q <= cur_d; step_q <= step_d; ptr_q <= ptr_d;
      left_q <= left_d; val_q <= val_d; ofs_q <= ofs_d;
    end
  end

  assign mem_addr_o = (st_q == S_RO_REQ) ? ptr_q + AW'(WORD_B) : ptr_q;
  assign wr_addr_o  = ofs_q;
  assign wr_data_o  = val_q;
  assign err_addr_o = ofs_q;

  AST_LEFT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WR) |-> (left_q != '0)); // R6
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o); // R3
  AST_OFS_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RO_WAIT && mem_rvalid_i && !mem_rerr_i) |=> wr_en_o); // R3
  AST_DB_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_FRAME && !frame_i) |=> !wr_en_o); // R4
endmodule

// File: rtl/reglist_loader.sv
module reglist_loader
  import reglist_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              frame_start,
  input  logic              display_active,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_valid,
  input  logic [DW-1:0]     rd_data,
  input  logic              rd_err,
  output logic              wr_en,
  output logic [DW-1:0]     wr_addr,
  output logic [DW-1:0]     wr_data,
  input  logic              wr_err,
  output logic              irq
);
  logic [1:0]       rs_q;
  logic             rst_i_n;
  logic             go, arb, clr_en;
  logic [AW-1:0]    db_base, sb_base;
  logic [CW-1:0]    db_cnt, hp_cnt, lp_cnt;
  logic [NFLAG-1:0] evt;
  logic [DW-1:0]    err_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  reglist_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .we_i(cfg_we), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .rdata_o(cfg_rdata), .evt_i(evt), .clr_en_i(clr_en),
    .err_addr_i(err_addr), .go_o(go), .arb_o(arb), .db_base_o(db_base),
    .db_cnt_o(db_cnt), .sb_base_o(sb_base), .hp_cnt_o(hp_cnt),
    .lp_cnt_o(lp_cnt), .irq_o(irq)
  );

  reglist_seq #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_i_n), .go_i(go), .arb_i(arb),
    .db_base_i(db_base), .db_cnt_i(db_cnt), .sb_base_i(sb_base),
    .hp_cnt_i(hp_cnt), .lp_cnt_i(lp_cnt), .frame_i(frame_start),
    .disp_i(display_active), .mem_req_o(rd_req), .mem_addr_o(rd_addr),
    .mem_rvalid_i(rd_valid), .mem_rdata_i(rd_data), .mem_rerr_i(rd_err),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_err_i(wr_err), .evt_o(evt), .clr_en_o(clr_en), .err_addr_o(err_addr)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(rst_i_n) |-> (!rd_req && !wr_en && !irq)); // R1
endmodule

// File: tb/reglist_loader_bench.sv
module reglist_loader_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        frame_start = 1'b0, display_active = 1'b0;
  logic        rd_req, rd_valid = 1'b0, rd_err = 1'b0;
  logic [31:0] rd_addr, rd_data = '0;
  logic        wr_en, wr_err, irq;
  logic [31:0] wr_addr, wr_data;
  logic [31:0] bad_rd = 32'hFFFF_FFFF, bad_wr = 32'hFFFF_FFFF;
  logic [63:0] expq[$];
  bit          trunc;
  int          nchk = 0, nfail = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  reglist_loader u_reglist_loader (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frame_start(frame_start),
    .display_active(display_active), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(wr_err), .irq(irq)
  );

  function automatic logic [31:0] mval(input logic [31:0] a);
    return (a * 32'h0001_0DCD) ^ 32'hA5A5_0000;
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    rd_valid <= rd_req;
    rd_data  <= mval(rd_addr);
    rd_err   <= rd_req && (rd_addr == bad_rd);
  end
  assign wr_err = wr_en && (wr_addr == bad_wr);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model: expected write stream, checked every clock
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (expq.size() == 0) chk("R4 unexpected write", {wr_addr, wr_data}, 64'hX);
      else chk("R3 write order/content", {wr_addr, wr_data}, expq.pop_front());
    end
  end

  task automatic add_list(input logic [31:0] base, input int cnt);
    for (int i = 0; i < cnt; i++) begin
      logic [31:0] a;
      a = base + 32'(8 * i);
      if (trunc) return;
      if (a == bad_rd || a + 32'd4 == bad_rd) begin trunc = 1; return; end
      expq.push_back({mval(a + 32'd4), mval(a)});
      if (mval(a + 32'd4) == bad_wr) begin trunc = 1; return; end
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic wait_q(input int n);
    int t = 0;
    while (expq.size() != n && t < 3000) begin @(negedge clk); #1; t++; end
    if (t >= 3000) chk("R4 queue wait timeout", 64'(expq.size()), 64'(n));
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    int t = 0;
    rd(6'h00, c);
    while (c[0] && t < 3000) begin rd(6'h00, c); t++; end
    if (t >= 3000) chk("R6 run bit never cleared", 64'(c), 64'h0);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    rd(6'h00, rv); chk("R1 ctl", 64'(rv), 64'h0);
    rd(6'h1C, rv); chk("R1 sbc", 64'(rv), 64'h0);
    rd(6'h20, rv); chk("R1 err", 64'(rv), 64'h0);
    chk("R1 irq/req/wr", {61'h0, irq, rd_req, wr_en}, 64'h0);

    // R2/R4/R6: urgent then relaxed, then double buffer on frame
    wr(6'h10, 32'h100); wr(6'h14, 32'd2);
    wr(6'h18, 32'h200); wr(6'h1C, 32'h0002_0003);
    rd(6'h1C, rv); chk("R2 packed counts", 64'(rv), 64'h0002_0003);
    trunc = 0; add_list(32'h200, 3); add_list(32'h218, 2); add_list(32'h100, 2);
    wr(6'h00, 32'h1FD);
    wait_q(2);
    repeat (20) @(negedge clk);
    chk("R4 double buffer holds for frame", 64'(expq.size()), 64'd2);
    rd(6'h00, rv); chk("R4 run bit during frame wait", 64'(rv[0]), 64'd1);
    pulse_frame();
    wait_idle();
    chk("R6 all writes done", 64'(expq.size()), 64'd0);
    rd(6'h00, rv); chk("R6 done flags and run cleared", 64'(rv), 64'h000E_01FC);
    chk("R12 irq raised", 64'(irq), 64'd1);

    // R7 write-one-to-clear
    wr(6'h00, 32'h0004_01FC);
    rd(6'h00, rv); chk("R7 single flag cleared", 64'(rv), 64'h000A_01FC);
    wr(6'h00, 32'h0000_0000);
    repeat (2) @(negedge clk);
    chk("R12 irq masked", 64'(irq), 64'd0);
    rd(6'h00, rv); chk("R7 zero write keeps flags", 64'(rv), 64'h000A_0000);
    wr(6'h00, 32'h007F_0000);
    rd(6'h00, rv); chk("R7 all cleared", 64'(rv), 64'h0);

    // R4/R5/R8: relaxed first, no double buffer, locked config
    wr(6'h14, 32'd0); wr(6'h1C, 32'h0002_0001);
    trunc = 0; add_list(32'h208, 2); add_list(32'h200, 1);
    wr(6'h00, 32'h3);
    wait_q(2);
    wr(6'h14, 32'd5); wr(6'h18, 32'h400); wr(6'h00, 32'h1);
    wait_idle();
    chk("R8 no restart", 64'(expq.size()), 64'd0);
    rd(6'h14, rv); chk("R8 count locked", 64'(rv), 64'd0);
    rd(6'h18, rv); chk("R8 base locked", 64'(rv), 64'h200);
    rd(6'h00, rv); chk("R5 skip db, order kept", 64'(rv), 64'h000C_0002);
    wr(6'h00, 32'h007F_0000);

    // R5 all counts zero
    wr(6'h1C, 32'h0);
    wr(6'h00, 32'h1);
    wait_idle();
    rd(6'h00, rv); chk("R5 empty run", 64'(rv), 64'h0);

    // R9 read error on entry 1 offset word
    wr(6'h1C, 32'h0000_0003);
    bad_rd = 32'h20C;
    trunc = 0; add_list(32'h200, 3);
    wr(6'h00, 32'h5);
    wait_idle();
    chk("R9 writes stopped", 64'(expq.size()), 64'd0);
    rd(6'h00, rv); chk("R9 read error flag", 64'(rv), 64'h0001_0004);
    chk("R12 irq on read error", 64'(irq), 64'd1);
    bad_rd = 32'hFFFF_FFFF;
    wr(6'h00, 32'h007F_0000);

    // R10 write error on entry 1
    bad_wr = mval(32'h20C);
    trunc = 0; add_list(32'h200, 3);
    wr(6'h00, 32'h1);
    wait_idle();
    chk("R10 writes stopped", 64'(expq.size()), 64'd0);
    rd(6'h00, rv); chk("R10 write error flag", 64'(rv), 64'h0040_0000);
    rd(6'h20, rv); chk("R10 failing offset", 64'(rv), 64'(mval(32'h20C)));
    chk("R12 irq stays low when disabled", 64'(irq), 64'd0);
    bad_wr = 32'hFFFF_FFFF;
    wr(6'h00, 32'h007F_0000);

    // R11 hazards during single-buffer replay
    wr(6'h14, 32'd1); wr(6'h1C, 32'h0000_0002);
    trunc = 0; add_list(32'h200, 2); add_list(32'h100, 1);
    wr(6'h00, 32'h1);
    wait_q(2);
    @(negedge clk); frame_start = 1'b1; display_active = 1'b1;
    @(negedge clk); frame_start = 1'b0; display_active = 1'b0;
    wait_q(1);
    repeat (10) @(negedge clk);
    chk("R11 early frame not consumed", 64'(expq.size()), 64'd1);
    pulse_frame();
    wait_idle();
    chk("R11 run completed", 64'(expq.size()), 64'd0);
    rd(6'h00, rv); chk("R11 hazard flags", 64'(rv), 64'h0036_0000);

    summary();
  end
endmodule